// File: doc/BRIEF.md
# Runt-Free Gated Clock Fanout

This block picks one of two incoming clocks and copies it onto five output pairs, each pair made of a true line and its inverse. A single enable input, which may change at any moment with no relation to either clock, decides whether the pairs toggle or rest. While resting, every true line is held low and every inverse line is held high.

The enable is passed through two registers before it reaches the output gate. The first register samples it on a rising edge of the selected clock. The second samples the first on the following falling edge. The gate therefore changes only while the selected clock is low. An output high pulse is then always a full high phase of the source clock and is never cut short. An active-low asynchronous reset clears both registers, so the outputs come up resting. The source select is meant to change only while the outputs rest.

Top module: `gated_clk_fanout`

## Requirements
- R1: With `src_sel` at 0 the outputs carry `clk_in0`. With `src_sel` at 1 they carry `clk_in1`.
- R2: While enabled, each `clk_out_t` bit equals the selected clock and each `clk_out_c` bit is its inverse.
- R3: While disabled, all `clk_out_t` bits are 0 and all `clk_out_c` bits are 1.
- R4: After `out_en` changes, the new state first shows in the high phase that follows one rising edge and then one falling edge of the selected clock. The high phase just after that rising edge still shows the old state.
- R5: All NUM_PAIRS pairs (5 by default) are enabled and disabled together and always carry identical values.
- R6: Every high pulse on a true output lasts exactly one full high phase of the selected clock, even when `out_en` toggles at arbitrary times.
- R7: While `rst_n` is 0 the outputs are disabled. After `rst_n` is released with `out_en` high, the outputs stay disabled until a rising edge and then a falling edge of the selected clock have occurred.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in0 | input | 1 | Source clock chosen when `src_sel` is 0 |
| clk_in1 | input | 1 | Source clock chosen when `src_sel` is 1 |
| src_sel | input | 1 | Source select |
| out_en | input | 1 | Asynchronous output enable, active high |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_out_t | output | NUM_PAIRS | True outputs |
| clk_out_c | output | NUM_PAIRS | Inverse outputs |

## Verification
The hardest case to reach is an enable edge that lands close to a source clock edge. A badly built gate would produce a clipped pulse only there. To reach that case, the bench toggles `out_en` hundreds of times at pseudo-random offsets that are not multiples of either clock period, on both sources. A monitor measures the width of every pulse on a true output against the high phase of the selected clock. Directed steps then place an enable change just after a falling edge to check the exact high phase in which the change first shows.

// File: rtl/gated_clk_fanout.sv
`timescale 1ns/1ps
module gated_clk_fanout #(
  parameter int NUM_PAIRS = 5
) (
  input  logic                 clk_in0,
  input  logic                 clk_in1,
  input  logic                 src_sel,
  input  logic                 out_en,
  input  logic                 rst_n,
  output logic [NUM_PAIRS-1:0] clk_out_t,
  output logic [NUM_PAIRS-1:0] clk_out_c
);

  logic src_clk;
  logic en_rise;
  logic en_fall;

  assign src_clk = src_sel ? clk_in1 : clk_in0;

  always_ff @(posedge src_clk or negedge rst_n)
    if (!rst_n) en_rise <= 1'b0;
    else        en_rise <= out_en;

  always_ff @(negedge src_clk or negedge rst_n)
    if (!rst_n) en_fall <= 1'b0;
    else        en_fall <= en_rise;

  assign clk_out_t = {NUM_PAIRS{src_clk & en_fall}};
  assign clk_out_c = ~clk_out_t;

  AST_PAIRS_AGREE: assert property (@(negedge src_clk) disable iff (!rst_n)
    (clk_out_t != '0) |-> (clk_out_t == '1)); // R5

  AST_LOW_BEFORE_RISE: assert property (@(posedge src_clk) disable iff (!rst_n)
    clk_out_t == '0); // R6

  AST_SYNC_LATENCY: assert property (@(negedge src_clk) disable iff (!rst_n)
    clk_out_t == {NUM_PAIRS{$past(en_rise)}}); // R4

  AST_OFF_LEVELS: assert property (@(negedge src_clk) disable iff (!rst_n)
    !$past(en_rise) |-> (clk_out_t == '0 && clk_out_c == '1)); // R3

endmodule

// File: tb/tb_gated_clk_fanout.sv
`timescale 1ns/1ps
module tb_gated_clk_fanout;
  localparam int N = 5;

  logic c0 = 1'b0, c1 = 1'b0, sel = 1'b0, en = 1'b0, rst_n = 1'b0;
  logic [N-1:0] qt, qc;
  int checks = 0, fails = 0;
  bit mon_on = 1'b0;
  realtime rise_t = 0.0;

  always #2.5 c0 = ~c0;
  always #4.0 c1 = ~c1;

  wire selck = sel ? c1 : c0;

  gated_clk_fanout #(.NUM_PAIRS(N)) dut (
    .clk_in0(c0), .clk_in1(c1), .src_sel(sel), .out_en(en), .rst_n(rst_n),
    .clk_out_t(qt), .clk_out_c(qc));

  task automatic chk(input bit ok, input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%b exp=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_pair(input logic [N-1:0] exp_t, input string req);
    chk(qt == exp_t, req, qt, exp_t);
    chk(qc == ~exp_t, {req, " complement"}, qc, ~exp_t);
  endtask

  always @(posedge qt[0]) rise_t = $realtime;
  always @(negedge qt[0]) if (mon_on) begin
    realtime w, e;
    w = $realtime - rise_t;
    e = sel ? 4.0 : 2.5;
    checks++;
    if (w < e - 0.01 || w > e + 0.01) begin
      fails++;
      $display("FAIL R6 pulse width act=%0.3f exp=%0.3f", w, e);
    end
  end

  // {src_sel, out_en}
  localparam logic [1:0] VEC [6] = '{2'b01, 2'b00, 2'b11, 2'b10, 2'b01, 2'b11};

  task automatic settle_off(input logic new_sel);
    en = 1'b0;
    repeat (3) @(negedge selck);
    sel = new_sel;
    repeat (3) @(negedge selck);
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    en = 1'b1;
    #7.3;
    chk_pair('0, "R7 held in reset");
    @(posedge c0); #0.5;
    chk_pair('0, "R7 reset high phase");
    @(negedge c0); #0.5 rst_n = 1'b1;
    @(posedge c0); #0.5;
    chk_pair('0, "R7 first phase after release");
    @(posedge c0); #0.5;
    chk_pair('1, "R7 on after rise and fall");

    for (int i = 0; i < 6; i++) begin
      settle_off(VEC[i][1]);
      en = VEC[i][0];
      repeat (3) @(negedge selck);
      for (int k = 0; k < 4; k++) begin
        @(posedge selck); #0.5;
        chk_pair({N{VEC[i][0]}}, VEC[i][0] ? "R1 R2 high phase" : "R3 disabled high phase");
        @(negedge selck); #0.5;
        chk_pair('0, VEC[i][0] ? "R1 R2 low phase" : "R3 disabled low phase");
      end
    end

    settle_off(1'b0);
    @(negedge selck); #0.5 en = 1'b1;
    @(posedge selck); #0.5;
    chk_pair('0, "R4 enable not yet visible");
    @(posedge selck); #0.5;
    chk_pair('1, "R4 enable visible");
    @(negedge selck); #0.5 en = 1'b0;
    @(posedge selck); #0.5;
    chk_pair('1, "R4 disable not yet visible");
    @(posedge selck); #0.5;
    chk_pair('0, "R4 disable visible");

    @(posedge selck); #1.0 rst_n = 1'b0; en = 1'b1;
    #0.2;
    chk_pair('0, "R7 async reset in high phase");
    @(negedge selck); #0.5 rst_n = 1'b1;

    for (int s = 0; s < 2; s++) begin
      settle_off(s[0]);
      mon_on = 1'b1;
      for (int j = 0; j < 300; j++) begin
        #($urandom_range(1, 97) * 0.13);
        en = ~en;
      end
      en = 1'b1;
      repeat (3) @(negedge selck);
      @(posedge selck); #0.5;
      chk_pair('1, "R5 all pairs on after toggling");
      mon_on = 1'b0;
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule